// File: doc/BRIEF.md
# UART Interrupt Status Controller

This block keeps the interrupt bookkeeping of a serial port. Eight sticky pending flags collect events from the transmit and receive paths. Eight enable flags gate them onto eight interrupt lines. A test register lets software force any flag. A separate alert-test register produces a one-cycle fatal alert pulse. The FIFOs, the serializer and the bus protocol sit outside. The block only sees event pulses, FIFO level values, threshold selections and a simple register strobe interface.

Two small state machines derive the transmit-side events:

- **Watermark machine.** It has the states `WM_BELOW` and `WM_ARMED`.
  - `BELOW -> ARMED` happens on a TX FIFO write that leaves the level at or above the threshold.
  - `ARMED -> BELOW (fire)` happens when the level drops under the threshold.
  - `ARMED -> BELOW (silent)` happens on a TX FIFO clear. A clear wins over a drop in the same cycle.
- **Empty machine.** It has the states `TXE_IDLE` and `TXE_BUSY`.
  - `IDLE -> BUSY` happens on a transmit start pulse.
  - `BUSY -> IDLE (fire)` happens once the TX level reads zero. If a new start arrives in that same cycle, the machine fires and stays `BUSY`.

The receive watermark flag is level-sensitive. The error events set their flags directly.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset all pending flags, all enable flags, every interrupt line and the alert output are 0.
- R2: Interrupt line i is high exactly when pending flag i and enable flag i are both set. Pending flags read at address 0x0, bit 0 TX watermark, 1 RX watermark, 2 TX empty, 3 RX overflow, 4 frame error, 5 break error, 6 RX timeout, 7 parity error.
- R3: Writing address 0x0 clears every pending flag whose data bit is 1 and leaves flags whose data bit is 0 untouched.
- R4: Writing address 0x8 sets every pending flag whose data bit is 1, and data bits of 0 change nothing. Reads of 0x8 and 0xC return 0.
- R5: The RX watermark flag is set in every cycle where the RX level is at or above the threshold picked by a 3-bit select. The select values map as follows: 0→1, 1→4, 2→8, 3→16, 4→30, any other value→1.
- R6: The TX watermark machine arms only on a TX FIFO write that leaves the level at or above the threshold picked by a 2-bit select: 0→2, 1→4, 2→8, 3→16. It sets the TX watermark flag once, when the level then drops below the threshold. A level that falls without having been armed sets nothing.
- R7: A TX FIFO clear returns the watermark machine to its unarmed state without setting the flag, also when the level drops in the same cycle.
- R8: After a transmit start pulse, the TX empty flag is set in the first cycle where the TX level is 0. Without a start pulse, a zero level sets nothing.
- R9: Pulses on the RX overflow, frame error, break error, timeout and parity error inputs set pending bits 3, 4, 5, 6 and 7 respectively.
- R10: When a hardware set and a write-one-to-clear hit the same flag in the same cycle, the flag ends up set.
- R11: Writing address 0xC with data bit 0 at 1 drives the alert output high for exactly the one cycle after the write. With data bit 0 at 0 there is no pulse.
- R12: The enable register at 0x4 stores data bits 7:0 and reads them back, and bits 31:8 of every read are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data (combinational, 0 when reg_rd is low) |
| tx_push | input | 1 | TX FIFO write happened this cycle |
| tx_clr | input | 1 | TX FIFO reset |
| tx_start | input | 1 | Transmission started |
| tx_level | input | LVL_W | Current TX FIFO level |
| tx_thr_sel | input | 2 | TX threshold select |
| rx_level | input | LVL_W | Current RX FIFO level |
| rx_thr_sel | input | 3 | RX threshold select |
| rx_ovf_evt | input | 1 | RX overflow pulse |
| rx_frame_evt | input | 1 | Frame error pulse |
| rx_break_evt | input | 1 | Break error pulse |
| rx_tmo_evt | input | 1 | RX timeout pulse |
| rx_par_evt | input | 1 | Parity error pulse |
| irq | output | 8 | Interrupt lines |
| alert | output | 1 | Fatal alert pulse |

## Verification
The hardest case to reach is a TX watermark interrupt that must not fire. Two situations qualify: a level drop that was never preceded by a qualifying write, and a drop that coincides with a FIFO clear. Both look identical at the level input to a drop that should fire. The stimulus therefore walks the TX level through the threshold by hand, with and without the push strobe and with the clear pulse in the same cycle as the drop. It reads the state register after each step. The same-cycle set-versus-clear race is produced by holding the RX level over its threshold while software clears the flag.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int NUM_IRQ = 8;

    // pending flag positions (software decodes these)
    localparam int B_TXWM  = 0;
    localparam int B_RXWM  = 1;
    localparam int B_TXE   = 2;
    localparam int B_OVF   = 3;
    localparam int B_FRAME = 4;
    localparam int B_BREAK = 5;
    localparam int B_TMO   = 6;
    localparam int B_PAR   = 7;

    // byte offsets
    localparam int OFS_STATE = 'h0;
    localparam int OFS_EN    = 'h4;
    localparam int OFS_TEST  = 'h8;
    localparam int OFS_ALERT = 'hC;

    typedef enum logic {WM_BELOW, WM_ARMED} wm_state_e;
    typedef enum logic {TXE_IDLE, TXE_BUSY} txe_state_e;

    function automatic int rx_thresh(input logic [2:0] sel);
        case (sel)
            3'd1:    return 4;
            3'd2:    return 8;
            3'd3:    return 16;
            3'd4:    return 30;
            default: return 1;
        endcase
    endfunction

    function automatic int tx_thresh(input logic [1:0] sel);
        case (sel)
            2'd1:    return 4;
            2'd2:    return 8;
            2'd3:    return 16;
            default: return 2;
        endcase
    endfunction

endpackage

// File: rtl/uart_irq_txwm.sv
module uart_irq_txwm
    import uart_irq_pkg::*;
#(
    parameter int LVL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             clr,
    input  logic [LVL_W-1:0] level,
    input  logic [1:0]       thr_sel,
    output logic             fire
);
    wm_state_e state, state_n;
    logic      at_or_above;

    assign at_or_above = int'(level) >= tx_thresh(thr_sel);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= WM_BELOW;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        fire    = 1'b0;
        unique case (state)
            WM_BELOW: begin
                if (!clr && push && at_or_above) state_n = WM_ARMED;
            end
            WM_ARMED: begin
                if (clr) begin
                    state_n = WM_BELOW;
                end else if (!at_or_above) begin
                    fire    = 1'b1;
                    state_n = WM_BELOW;
                end
            end
        endcase
    end
endmodule

// File: rtl/uart_irq_txempty.sv
module uart_irq_txempty
    import uart_irq_pkg::*;
#(
    parameter int LVL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LVL_W-1:0] level,
    output logic             fire
);
    txe_state_e state, state_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TXE_IDLE;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        fire    = 1'b0;
        unique case (state)
            TXE_IDLE: begin
                if (start) state_n = TXE_BUSY;
            end
            TXE_BUSY: begin
                if (level == '0) begin
                    fire    = 1'b1;
                    state_n = start ? TXE_BUSY : TXE_IDLE;
                end
            end
        endcase
    end
endmodule

// File: rtl/uart_irq_regs.sv
module uart_irq_regs
    import uart_irq_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic               rd,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [NUM_IRQ-1:0] hw_set,
    output logic [NUM_IRQ-1:0] pend,
    output logic [NUM_IRQ-1:0] en,
    output logic [DATA_W-1:0]  rdata,
    output logic               alert
);
    localparam logic [ADDR_W-1:0] A_STATE = ADDR_W'(OFS_STATE);
    localparam logic [ADDR_W-1:0] A_EN    = ADDR_W'(OFS_EN);
    localparam logic [ADDR_W-1:0] A_TEST  = ADDR_W'(OFS_TEST);
    localparam logic [ADDR_W-1:0] A_ALERT = ADDR_W'(OFS_ALERT);

    logic               wr_state, wr_en, wr_test, wr_alert;
    logic [NUM_IRQ-1:0] clr_mask, test_mask, pend_n;

    assign wr_state = wr && (addr == A_STATE);
    assign wr_en    = wr && (addr == A_EN);
    assign wr_test  = wr && (addr == A_TEST);
    assign wr_alert = wr && (addr == A_ALERT);

    assign clr_mask  = wr_state ? wdata[NUM_IRQ-1:0] : '0;
    assign test_mask = wr_test  ? wdata[NUM_IRQ-1:0] : '0;

    // set sources are applied after the clear, so a set wins
    assign pend_n = (pend & ~clr_mask) | hw_set | test_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend  <= '0;
            en    <= '0;
            alert <= 1'b0;
        end else begin
            pend  <= pend_n;
            alert <= wr_alert && wdata[0];
            if (wr_en) en <= wdata[NUM_IRQ-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        if (rd) begin
            case (addr)
                A_STATE: rdata[NUM_IRQ-1:0] = pend;
                A_EN:    rdata[NUM_IRQ-1:0] = en;
                default: rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int LVL_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              tx_push,
    input  logic              tx_clr,
    input  logic              tx_start,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [1:0]        tx_thr_sel,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic [2:0]        rx_thr_sel,
    input  logic              rx_ovf_evt,
    input  logic              rx_frame_evt,
    input  logic              rx_break_evt,
    input  logic              rx_tmo_evt,
    input  logic              rx_par_evt,
    output logic [7:0]        irq,
    output logic              alert
);
    logic [NUM_IRQ-1:0] hw_set, pend, en;
    logic               txwm_fire, txe_fire, rxwm_hit;

    uart_irq_txwm #(.LVL_W(LVL_W)) u_txwm (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .clr(tx_clr),
        .level(tx_level), .thr_sel(tx_thr_sel), .fire(txwm_fire)
    );

    uart_irq_txempty #(.LVL_W(LVL_W)) u_txe (
        .clk(clk), .rst_n(rst_n), .start(tx_start),
        .level(tx_level), .fire(txe_fire)
    );

    assign rxwm_hit = int'(rx_level) >= rx_thresh(rx_thr_sel);

    always_comb begin
        hw_set          = '0;
        hw_set[B_TXWM]  = txwm_fire;
        hw_set[B_RXWM]  = rxwm_hit;
        hw_set[B_TXE]   = txe_fire;
        hw_set[B_OVF]   = rx_ovf_evt;
        hw_set[B_FRAME] = rx_frame_evt;
        hw_set[B_BREAK] = rx_break_evt;
        hw_set[B_TMO]   = rx_tmo_evt;
        hw_set[B_PAR]   = rx_par_evt;
    end

    uart_irq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
        .wdata(reg_wdata), .hw_set(hw_set), .pend(pend), .en(en),
        .rdata(reg_rdata), .alert(alert)
    );

    genvar gi;
    generate
        for (gi = 0; gi < NUM_IRQ; gi++) begin : g_line
            assign irq[gi] = pend[gi] & en[gi];
        end
    endgenerate
endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [7:0]        hw_set,
    input logic [7:0]        pend,
    input logic [7:0]        en,
    input logic [7:0]        irq,
    input logic              alert
);
    localparam logic [ADDR_W-1:0] A_STATE = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_TEST  = ADDR_W'(8);
    localparam logic [ADDR_W-1:0] A_ALERT = ADDR_W'(12);

    // R2
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en == 8'h00 || pend == 8'h00) |-> irq == 8'h00);

    // R3
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_STATE && hw_set == 8'h00)
        |=> (pend & $past(reg_wdata[7:0])) == 8'h00);

    // R4
    test_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_TEST)
        |=> (pend & $past(reg_wdata[7:0])) == $past(reg_wdata[7:0]));

    // R10
    hw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_set != 8'h00) |=> (pend & $past(hw_set)) == $past(hw_set));

    // R11
    alert_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_ALERT && reg_wdata[0]) |=> alert);

    // R11
    alert_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alert) |-> $past(reg_wr && reg_addr == A_ALERT && reg_wdata[0]));
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .hw_set(hw_set), .pend(pend), .en(en),
    .irq(irq), .alert(alert)
);

// File: tb/uart_irq_ctrl_test.sv
module uart_irq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [3:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        tx_push = 0, tx_clr = 0, tx_start = 0;
    logic [5:0]  tx_level = 0, rx_level = 0;
    logic [1:0]  tx_thr_sel = 0;
    logic [2:0]  rx_thr_sel = 0;
    logic        rx_ovf_evt = 0, rx_frame_evt = 0, rx_break_evt = 0;
    logic        rx_tmo_evt = 0, rx_par_evt = 0;
    logic [7:0]  irq;
    logic        alert;
    int          checks = 0, errors = 0;

    always #5 clk = ~clk;

    uart_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_push(tx_push), .tx_clr(tx_clr), .tx_start(tx_start),
        .tx_level(tx_level), .tx_thr_sel(tx_thr_sel), .rx_level(rx_level),
        .rx_thr_sel(rx_thr_sel), .rx_ovf_evt(rx_ovf_evt),
        .rx_frame_evt(rx_frame_evt), .rx_break_evt(rx_break_evt),
        .rx_tmo_evt(rx_tmo_evt), .rx_par_evt(rx_par_evt),
        .irq(irq), .alert(alert)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 0; reg_wdata = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_rd = 1; reg_addr = a;
        #1 d = reg_rdata;
        reg_rd = 0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(4'h0, v); chk("R1 pending", v, 0);
        rd(4'h4, v); chk("R1 enable", v, 0);
        chk("R1 irq", {24'b0, irq}, 0);
        chk("R1 alert", {31'b0, alert}, 0);
    endtask

    task automatic t_enable();
        logic [31:0] v;
        wr(4'h4, 32'hFFFF_FF5A);
        rd(4'h4, v); chk("R12 enable readback", v, 32'h5A);
        wr(4'h4, 32'hFFFF_FFFF);
        rd(4'h4, v); chk("R12 upper bits zero", v, 32'hFF);
    endtask

    task automatic t_test_w1c();
        logic [31:0] v;
        wr(4'h8, 32'h05);
        rd(4'h0, v); chk("R4 test set", v, 32'h05);
        chk("R2 irq all enabled", {24'b0, irq}, 32'h05);
        wr(4'h8, 32'h00);
        rd(4'h0, v); chk("R4 test zero no effect", v, 32'h05);
        rd(4'h8, v); chk("R4 test reads zero", v, 0);
        wr(4'h4, 32'h01);
        chk("R2 irq gated", {24'b0, irq}, 32'h01);
        wr(4'h0, 32'h04);
        rd(4'h0, v); chk("R3 w1c one bit", v, 32'h01);
        wr(4'h0, 32'h00);
        rd(4'h0, v); chk("R3 w1c zero keeps", v, 32'h01);
        wr(4'h0, 32'hFF);
        rd(4'h0, v); chk("R3 w1c all", v, 0);
        wr(4'h4, 32'hFF);
    endtask

    task automatic t_rx_wm();
        logic [31:0] v;
        rx_thr_sel = 3'd1; rx_level = 3; step();
        rd(4'h0, v); chk("R5 below thr 4", v, 0);
        rx_level = 4; step();
        rd(4'h0, v); chk("R5 at thr 4", v, 32'h02);
        wr(4'h0, 32'h02);
        rd(4'h0, v); chk("R10 set wins over clear", v, 32'h02);
        rx_thr_sel = 3'd4; rx_level = 29; step();
        wr(4'h0, 32'h02);
        rd(4'h0, v); chk("R5 below thr 30", v, 0);
        rx_level = 30; step();
        rd(4'h0, v); chk("R5 at thr 30", v, 32'h02);
        rx_thr_sel = 3'd7; rx_level = 0; step();
        wr(4'h0, 32'h02);
        rd(4'h0, v); chk("R5 sel 7 means 1, level 0", v, 0);
        rx_level = 1; step();
        rd(4'h0, v); chk("R5 sel 7 means 1, level 1", v, 32'h02);
        rx_level = 0; rx_thr_sel = 0; step();
        wr(4'h0, 32'hFF);
    endtask

    task automatic t_tx_wm();
        logic [31:0] v;
        tx_thr_sel = 2'd0;
        tx_level = 1; tx_push = 1; step(); tx_push = 0;
        tx_level = 0; step();
        rd(4'h0, v); chk("R6 no arm below thr", v, 0);
        tx_level = 3; step(); tx_level = 1; step();
        rd(4'h0, v); chk("R6 no arm without push", v, 0);
        tx_level = 2; tx_push = 1; step(); tx_push = 0;
        step();
        rd(4'h0, v); chk("R6 armed holds at thr", v, 0);
        tx_level = 1; step();
        rd(4'h0, v); chk("R6 fires on drop", v, 32'h01);
        wr(4'h0, 32'h01);
        tx_level = 0; step();
        rd(4'h0, v); chk("R6 fires once", v, 0);
    endtask

    task automatic t_tx_clr();
        logic [31:0] v;
        tx_thr_sel = 2'd1;
        tx_level = 5; tx_push = 1; step(); tx_push = 0;
        tx_level = 0; tx_clr = 1; step(); tx_clr = 0;
        step();
        rd(4'h0, v); chk("R7 clear disarms", v, 0);
        tx_level = 3; step(); tx_level = 0; step();
        rd(4'h0, v); chk("R7 stays unarmed", v, 0);
        tx_thr_sel = 0;
    endtask

    task automatic t_tx_empty();
        logic [31:0] v;
        tx_level = 0; step();
        rd(4'h0, v); chk("R8 no start no flag", v, 0);
        tx_level = 3; tx_start = 1; step(); tx_start = 0;
        step();
        rd(4'h0, v); chk("R8 busy not empty", v, 0);
        tx_level = 0; step();
        rd(4'h0, v); chk("R8 empty after start", v, 32'h04);
        wr(4'h0, 32'h04); step();
        rd(4'h0, v); chk("R8 single event", v, 0);
    endtask

    task automatic t_errors();
        logic [31:0] v;
        rx_ovf_evt = 1; step(); rx_ovf_evt = 0;
        rd(4'h0, v); chk("R9 overflow bit3", v, 32'h08);
        rx_frame_evt = 1; step(); rx_frame_evt = 0;
        rd(4'h0, v); chk("R9 frame bit4", v, 32'h18);
        rx_break_evt = 1; step(); rx_break_evt = 0;
        rd(4'h0, v); chk("R9 break bit5", v, 32'h38);
        rx_tmo_evt = 1; step(); rx_tmo_evt = 0;
        rd(4'h0, v); chk("R9 timeout bit6", v, 32'h78);
        rx_par_evt = 1; step(); rx_par_evt = 0;
        rd(4'h0, v); chk("R9 parity bit7", v, 32'hF8);
        chk("R2 irq errors", {24'b0, irq}, 32'hF8);
        wr(4'h0, 32'hFF);
    endtask

    task automatic t_alert();
        logic [31:0] v;
        wr(4'hC, 32'h1);
        chk("R11 alert high", {31'b0, alert}, 1);
        step();
        chk("R11 alert one cycle", {31'b0, alert}, 0);
        wr(4'hC, 32'hFFFF_FFFE);
        chk("R11 bit0 zero no alert", {31'b0, alert}, 0);
        rd(4'hC, v); chk("R4 alert reads zero", v, 0);
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        t_reset();
        rst_n = 1;
        step();
        t_reset();
        t_enable();
        t_test_w1c();
        t_rx_wm();
        t_tx_wm();
        t_tx_clr();
        t_tx_empty();
        t_errors();
        t_alert();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule